// File: doc/BRIEF.md
# Packed Lane Shuffle Unit

This block rearranges the 32-bit lanes of two 128-bit operands, a destination and a source, into one 128-bit result. The 32-bit lanes are treated as opaque data; the block does no arithmetic. The operation arrives already decoded as a 3-bit code. An 8-bit select immediate is used only by the full shuffle, where it picks which lane feeds each result position. The other operations are fixed patterns: two interleaves and two 64-bit half moves. They share the same datapath and the same output register.

A caller presents the operands with `in_valid` high for one cycle. The registered result appears on `out_data`, with `out_valid` high, on the next cycle. A new operation can be issued on every cycle.

A small controller holds the valid state. It has two states, `ST_IDLE` and `ST_RESULT`, and these transitions:
- Reset moves the controller to `ST_IDLE`.
- `ST_IDLE` goes to `ST_RESULT` when `in_valid` is high.
- `ST_RESULT` stays in `ST_RESULT` when `in_valid` is high.
- `ST_RESULT` goes back to `ST_IDLE` when `in_valid` is low.

Lane k occupies bits [32k+31:32k].

Top module: `lane_permute_unit`

## Requirements
- R1: A synchronous active-high `rst` sets `out_valid` to 0 and `out_data` to all zeros on the next clock edge.
- R2: `out_valid` is 1 exactly in the cycle after a cycle in which `in_valid` was 1, and 0 otherwise, including back-to-back issues.
- R3: While `in_valid` is 0, `out_data` keeps its last value, whatever the other inputs do.
- R4: Op code 0 (shuffle): result lane i (i = 0, 1) is destination lane `in_sel[2i+1:2i]`, and result lane i (i = 2, 3) is source lane `in_sel[2i+1:2i]`.
- R5: Shuffle with select 0x00, an all-ones destination and an all-zero source gives ones in bits [63:0] and zeros in bits [127:64].
- R6: Op code 1 (high interleave): result lanes 0..3 are destination lane 2, source lane 2, destination lane 3, source lane 3.
- R7: Op code 2 (low interleave): result lanes 0..3 are destination lane 0, source lane 0, destination lane 1, source lane 1.
- R8: Op code 3 (high-to-low move): result bits [63:0] are source bits [127:64], and result bits [127:64] are destination bits [127:64].
- R9: Op code 4 (low-to-high move): result bits [127:64] are source bits [63:0], and result bits [63:0] are destination bits [63:0].
- R10: Op codes 5, 6 and 7 return the destination operand unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and op code are valid this cycle |
| in_op | input | 3 | Decoded operation code |
| in_sel | input | 8 | Shuffle select immediate, two bits per result lane |
| in_dst | input | 128 | Destination operand, four 32-bit lanes |
| in_src | input | 128 | Source operand, four 32-bit lanes |
| out_valid | output | 1 | Result on `out_data` is new this cycle |
| out_data | output | 128 | Registered permuted result |

## Verification
The only internal state is the controller state and the output register. A controller stuck in `ST_RESULT`, or one that misses the return to `ST_IDLE`, shows up as a wrong `out_valid` one cycle after the first idle input. A missing load enable, or a spurious one, shows up as `out_data` changing or failing to change in that same cycle. A wrong lane route is seen on the very next cycle, in the lane that route feeds. Random operands make every lane value distinct, so a misroute cannot hide behind equal data.

// File: rtl/perm_pkg.sv
package perm_pkg;
    localparam int unsigned OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_SHUF   = 3'd0,
        OP_ILV_HI = 3'd1,
        OP_ILV_LO = 3'd2,
        OP_MOV_HL = 3'd3,
        OP_MOV_LH = 3'd4
    } perm_op_e;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } perm_state_e;
endpackage

// File: rtl/lane_select.sv
module lane_select #(
    parameter int unsigned LANE_W = 32,
    parameter int unsigned LANES  = 4,
    localparam int unsigned SEL_W = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int unsigned VEC_W = LANE_W * LANES
) (
    input  logic [VEC_W-1:0]  vec,
    input  logic [SEL_W-1:0]  idx,
    output logic [LANE_W-1:0] lane
);
    always_comb begin
        lane = '0;
        for (int i = 0; i < int'(LANES); i++) begin
            if (idx == SEL_W'(i)) begin
                lane = vec[i*LANE_W +: LANE_W];
            end
        end
    end
endmodule

// File: rtl/perm_datapath.sv
module perm_datapath
    import perm_pkg::*;
#(
    parameter int unsigned LANE_W = 32,
    parameter int unsigned LANES  = 4,
    localparam int unsigned SEL_W  = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int unsigned IMM_W  = SEL_W * LANES,
    localparam int unsigned VEC_W  = LANE_W * LANES,
    localparam int unsigned HALF_L = LANES / 2,
    localparam int unsigned HALF_W = LANE_W * HALF_L
) (
    input  logic [OP_W-1:0]  in_op,
    input  logic [IMM_W-1:0] in_sel,
    input  logic [VEC_W-1:0] in_dst,
    input  logic [VEC_W-1:0] in_src,
    output logic [VEC_W-1:0] result
);
    logic [VEC_W-1:0] shuf_v;
    logic [VEC_W-1:0] ilv_hi_v;
    logic [VEC_W-1:0] ilv_lo_v;
    logic [VEC_W-1:0] mov_hl_v;
    logic [VEC_W-1:0] mov_lh_v;
    perm_op_e         op_e;

    assign op_e = perm_op_e'(in_op);

    // Shuffle: the lower half of the result draws on the destination,
    // the upper half on the source; each position has its own select field.
    for (genvar gi = 0; gi < int'(LANES); gi++) begin : g_shuf
        if (gi < int'(HALF_L)) begin : g_from_dst
            lane_select #(.LANE_W(LANE_W), .LANES(LANES)) u_sel (
                .vec  (in_dst),
                .idx  (in_sel[gi*SEL_W +: SEL_W]),
                .lane (shuf_v[gi*LANE_W +: LANE_W])
            );
        end else begin : g_from_src
            lane_select #(.LANE_W(LANE_W), .LANES(LANES)) u_sel (
                .vec  (in_src),
                .idx  (in_sel[gi*SEL_W +: SEL_W]),
                .lane (shuf_v[gi*LANE_W +: LANE_W])
            );
        end
    end

    // Interleave: alternate destination and source lanes from one half.
    for (genvar gj = 0; gj < int'(HALF_L); gj++) begin : g_ilv
        assign ilv_hi_v[(2*gj)*LANE_W   +: LANE_W] = in_dst[(HALF_L+gj)*LANE_W +: LANE_W];
        assign ilv_hi_v[(2*gj+1)*LANE_W +: LANE_W] = in_src[(HALF_L+gj)*LANE_W +: LANE_W];
        assign ilv_lo_v[(2*gj)*LANE_W   +: LANE_W] = in_dst[gj*LANE_W +: LANE_W];
        assign ilv_lo_v[(2*gj+1)*LANE_W +: LANE_W] = in_src[gj*LANE_W +: LANE_W];
    end

    // Half moves: one half comes from the source, the other keeps the destination.
    assign mov_hl_v = {in_dst[VEC_W-1:HALF_W], in_src[VEC_W-1:HALF_W]};
    assign mov_lh_v = {in_src[HALF_W-1:0],     in_dst[HALF_W-1:0]};

    always_comb begin
        unique case (op_e)
            OP_SHUF:   result = shuf_v;
            OP_ILV_HI: result = ilv_hi_v;
            OP_ILV_LO: result = ilv_lo_v;
            OP_MOV_HL: result = mov_hl_v;
            OP_MOV_LH: result = mov_lh_v;
            default:   result = in_dst;
        endcase
    end
endmodule

// File: rtl/perm_ctrl.sv
module perm_ctrl
    import perm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic load_en,
    output logic out_valid
);
    perm_state_e state_q;
    perm_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = in_valid ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        out_valid = (state_q == ST_RESULT);
        load_en   = in_valid;
    end

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_valid_drops_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
endmodule

// File: rtl/lane_permute_unit.sv
module lane_permute_unit
    import perm_pkg::*;
#(
    parameter int unsigned LANE_W = 32,
    parameter int unsigned LANES  = 4,
    localparam int unsigned SEL_W  = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int unsigned IMM_W  = SEL_W * LANES,
    localparam int unsigned VEC_W  = LANE_W * LANES,
    localparam int unsigned HALF_W = LANE_W * (LANES / 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [2:0]       in_op,
    input  logic [IMM_W-1:0] in_sel,
    input  logic [VEC_W-1:0] in_dst,
    input  logic [VEC_W-1:0] in_src,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_data
);
    logic             load_en;
    logic [VEC_W-1:0] perm_res;
    logic             rst_q;

    perm_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .load_en   (load_en),
        .out_valid (out_valid)
    );

    perm_datapath #(.LANE_W(LANE_W), .LANES(LANES)) u_dp (
        .in_op  (in_op),
        .in_sel (in_sel),
        .in_dst (in_dst),
        .in_src (in_src),
        .result (perm_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_data <= '0;
        end else if (load_en) begin
            out_data <= perm_res;
        end
    end

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst_q) begin
            assert_reset_clears_R1: assert (!out_valid && out_data == '0);
        end
    end

    assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));
    assert_hl_keeps_upper_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == OP_MOV_HL) |=>
            out_data[VEC_W-1:HALF_W] == $past(in_dst[VEC_W-1:HALF_W]));
    assert_lh_keeps_lower_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == OP_MOV_LH) |=>
            out_data[HALF_W-1:0] == $past(in_dst[HALF_W-1:0]));
endmodule

// File: tb/sim_lane_permute_unit.sv
module sim_lane_permute_unit;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [2:0]   in_op;
    logic [7:0]   in_sel;
    logic [127:0] in_dst;
    logic [127:0] in_src;
    logic         out_valid;
    logic [127:0] out_data;

    int tests  = 0;
    int failed = 0;
    bit done   = 1'b0;
    logic [127:0] last_res;

    always #5 clk = ~clk;

    lane_permute_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_sel(in_sel), .in_dst(in_dst), .in_src(in_src),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [127:0] model(input logic [2:0] op, input logic [7:0] sel,
                                           input logic [127:0] d, input logic [127:0] s);
        logic [31:0] dl [4];
        logic [31:0] sl [4];
        logic [31:0] rl [4];
        for (int k = 0; k < 4; k++) begin
            dl[k] = d[32*k +: 32];
            sl[k] = s[32*k +: 32];
        end
        case (op)
            3'd0: begin
                rl[0] = dl[sel[1:0]]; rl[1] = dl[sel[3:2]];
                rl[2] = sl[sel[5:4]]; rl[3] = sl[sel[7:6]];
            end
            3'd1: begin rl[0] = dl[2]; rl[1] = sl[2]; rl[2] = dl[3]; rl[3] = sl[3]; end
            3'd2: begin rl[0] = dl[0]; rl[1] = sl[0]; rl[2] = dl[1]; rl[3] = sl[1]; end
            3'd3: begin rl[0] = sl[2]; rl[1] = sl[3]; rl[2] = dl[2]; rl[3] = dl[3]; end
            3'd4: begin rl[0] = dl[0]; rl[1] = dl[1]; rl[2] = sl[0]; rl[3] = sl[1]; end
            default: begin rl[0] = dl[0]; rl[1] = dl[1]; rl[2] = dl[2]; rl[3] = dl[3]; end
        endcase
        return {rl[3], rl[2], rl[1], rl[0]};
    endfunction

    function automatic string op_tag(input logic [2:0] op);
        case (op)
            3'd0: return "R4";
            3'd1: return "R6";
            3'd2: return "R7";
            3'd3: return "R8";
            3'd4: return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; issues one op and checks it one edge later.
    task automatic send(input logic [2:0] op, input logic [7:0] sel,
                        input logic [127:0] d, input logic [127:0] s, input string tag);
        logic [127:0] exp;
        in_valid = 1'b1; in_op = op; in_sel = sel; in_dst = d; in_src = s;
        exp = model(op, sel, d, s);
        @(negedge clk);
        chk("R2", {127'd0, out_valid}, 128'd1);
        chk(tag, out_data, exp);
        last_res = exp;
    endtask

    task automatic idle_cycle();
        in_valid = 1'b0; in_op = 3'($urandom); in_sel = 8'($urandom);
        in_dst = rnd128(); in_src = rnd128();
        @(negedge clk);
        chk("R2", {127'd0, out_valid}, 128'd0);
        chk("R3", out_data, last_res);
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; in_valid = 1'b0; in_op = '0; in_sel = '0; in_dst = '0; in_src = '0;
        repeat (3) @(negedge clk);
        chk("R1", {127'd0, out_valid}, 128'd0);
        chk("R1", out_data, 128'd0);
        rst = 1'b0;
        @(negedge clk);

        send(3'd0, 8'h00, {128{1'b1}}, 128'd0, "R5");
        chk("R5", out_data, {{64{1'b0}}, {64{1'b1}}});
        send(3'd0, 8'h1B, rnd128(), rnd128(), "R4");
        send(3'd0, 8'hE4, rnd128(), rnd128(), "R4");
        send(3'd1, 8'hFF, rnd128(), rnd128(), "R6");
        send(3'd2, 8'hFF, rnd128(), rnd128(), "R7");
        idle_cycle();
        send(3'd3, 8'h00, rnd128(), rnd128(), "R8");
        send(3'd4, 8'h00, rnd128(), rnd128(), "R9");
        for (int c = 5; c < 8; c++) send(3'(c), 8'($urandom), rnd128(), rnd128(), "R10");
        idle_cycle();
        idle_cycle();

        for (int n = 0; n < 300; n++) begin
            logic [2:0] op;
            op = 3'($urandom_range(0, 7));
            send(op, 8'($urandom), rnd128(), rnd128(), op_tag(op));
            if ($urandom_range(0, 3) == 0) idle_cycle();
        end

        // Reset in the middle of traffic
        send(3'd1, 8'h00, rnd128(), rnd128(), "R6");
        rst = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        chk("R1", {127'd0, out_valid}, 128'd0);
        chk("R1", out_data, 128'd0);
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            failed++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end
endmodule